// File: doc/BRIEF.md
# Modem Line Change Monitor

This block watches four asynchronous modem handshake lines (clear to send, data set ready, ring indicator and carrier detect). It brings each line into the clock domain and detects changes on it. Each detected change is held in a sticky flag, and the block raises an interrupt request while any flag is set. Software, or a bus wrapper in front of the block, reads one 8-bit status word. That word shows which lines have changed since the last read and the present level of every line.

A read strobe clears every pending flag at once and drops the interrupt, with one exception: a change detected in the same cycle as the read is kept. Three of the lines flag a change in either direction. The ring line flags only its rising edge. The interrupt comes out on its own pin, so an external encoder can rank it against other sources.

Top module: `modem_status_watch`

## Requirements
- R1: A level change in either direction on clear to send, data set ready or carrier detect sets that line's flag. The flags sit at status bit 0 (clear to send), bit 1 (data set ready) and bit 3 (carrier detect).
- R2: A low-to-high change on the ring line sets status bit 2. A high-to-low change on the ring line leaves bit 2 and the interrupt unchanged.
- R3: A set flag stays set until a read strobe arrives.
- R4: A cycle with `statusRd` high clears all four flags at the next clock edge. With no new change detected in that cycle, `modemIrq` is low afterwards.
- R5: `modemIrq` is high exactly when at least one of status bits [3:0] is set.
- R6: Status bits [7:4] give the synchronized levels: bit 4 clear to send, bit 5 data set ready, bit 6 ring, bit 7 carrier detect. An input change is driven before clock edge k. The new level appears after edge k+1, and the flag appears after edge k+2.
- R7: A change detected in the same cycle as a read strobe sets its flag and keeps it set after that read. Flags that were already pending are cleared by the read.
- R8: Reset (synchronous, active low, at least three cycles) clears all flags. The first cycles after reset flag nothing for lines that were steady during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| clearSendIn | input | 1 | Asynchronous clear-to-send line |
| setReadyIn | input | 1 | Asynchronous data-set-ready line |
| ringIn | input | 1 | Asynchronous ring-indicator line |
| carrierIn | input | 1 | Asynchronous carrier-detect line |
| statusRd | input | 1 | Read strobe, clears the flags at the next edge |
| statusData | output | 8 | {levels[3:0], flags[3:0]} |
| modemIrq | output | 1 | Modem status interrupt request |

## Verification
The assertions check four things every cycle, using only the status word: a level change sets the matching flag, a falling ring edge is ignored, flags stay sticky without a read, and a read with no new change clears everything. Some behaviours can only be shown by the bench scenarios. These are the exact two- and three-edge latency from an asynchronous pin, the clean state after reset with lines held high, and a read that lands in the same cycle as a new change. In those scenarios, a behavioural model is compared with the outputs every cycle.

// File: rtl/modem_watch_pkg.sv
package modem_watch_pkg;
  localparam int LINE_COUNT = 4;
  localparam int SYNC_DEPTH = 2;
  // line index order: 0 clear to send, 1 data set ready, 2 ring, 3 carrier
  localparam logic [LINE_COUNT-1:0] RISE_ONLY_MASK = 4'b0100;

  typedef struct packed {
    logic initLines;
    logic clearFlags;
  } watchStrobe_t;
endpackage

// File: rtl/modem_line_sync.sv
module modem_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    chain[0] <= asyncIn;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/modem_watch_ctl.sv
module modem_watch_ctl
  import modem_watch_pkg::*;
(
  input  logic         rstN,
  input  logic         statusRd,
  output watchStrobe_t strobe
);
  always_comb begin
    strobe.initLines  = !rstN;
    strobe.clearFlags = rstN && statusRd;
  end
endmodule

// File: rtl/modem_watch_dp.sv
module modem_watch_dp
  import modem_watch_pkg::*;
#(
  parameter int              LINES     = LINE_COUNT,
  parameter int              STAGES    = SYNC_DEPTH,
  parameter logic [LINES-1:0] RISE_ONLY = RISE_ONLY_MASK
) (
  input  logic             clk,
  input  watchStrobe_t     strobe,
  input  logic [LINES-1:0] lineIn,
  output logic [LINES-1:0] levelOut,
  output logic [LINES-1:0] flagOut,
  output logic             irqOut
);
  logic [LINES-1:0] lineLevel;
  logic [LINES-1:0] prevLevel;
  logic [LINES-1:0] edgeHit;
  logic [LINES-1:0] flagQ;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      modem_line_sync #(.STAGES(STAGES)) u_sync (
        .clk     (clk),
        .asyncIn (lineIn[i]),
        .syncOut (lineLevel[i])
      );
      if (RISE_ONLY[i]) begin : g_rise
        assign edgeHit[i] = lineLevel[i] & ~prevLevel[i];
      end else begin : g_any
        assign edgeHit[i] = lineLevel[i] ^ prevLevel[i];
      end
    end
  endgenerate

  // prevLevel tracks the line through reset so release flags nothing
  always_ff @(posedge clk) begin
    prevLevel <= lineLevel;
    if (strobe.initLines) begin
      flagQ <= '0;
    end else begin
      // a fresh edge wins over the clear
      flagQ <= (flagQ & ~{LINES{strobe.clearFlags}}) | edgeHit;
    end
  end

  assign levelOut = lineLevel;
  assign flagOut  = flagQ;
  assign irqOut   = |flagQ;
endmodule

// File: rtl/modem_status_watch.sv
module modem_status_watch
  import modem_watch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clearSendIn,
  input  logic       setReadyIn,
  input  logic       ringIn,
  input  logic       carrierIn,
  input  logic       statusRd,
  output logic [7:0] statusData,
  output logic       modemIrq
);
  watchStrobe_t          strobe;
  logic [LINE_COUNT-1:0] levels;
  logic [LINE_COUNT-1:0] flags;

  modem_watch_ctl u_ctl (
    .rstN     (rstN),
    .statusRd (statusRd),
    .strobe   (strobe)
  );

  modem_watch_dp #(
    .LINES     (LINE_COUNT),
    .STAGES    (SYNC_DEPTH),
    .RISE_ONLY (RISE_ONLY_MASK)
  ) u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .lineIn   ({carrierIn, ringIn, setReadyIn, clearSendIn}),
    .levelOut (levels),
    .flagOut  (flags),
    .irqOut   (modemIrq)
  );

  assign statusData = {levels, flags};
endmodule

// File: rtl/modem_status_chk.sv
module modem_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       statusRd,
  input logic [7:0] statusData,
  input logic       modemIrq
);
  // R1
  cts_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusData[4] != $past(statusData[4])) |=> statusData[0]);

  // R1
  dcd_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusData[7] != $past(statusData[7])) |=> statusData[3]);

  // R2
  ring_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusData[6]) |=> statusData[2]);

  // R2
  ring_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!statusData[2] && !statusRd && $fell(statusData[6])) |=> !statusData[2]);

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusRd |=> ((statusData[3:0] & $past(statusData[3:0])) == $past(statusData[3:0])));

  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && statusData[7:4] == $past(statusData[7:4])) |=> (statusData[3:0] == 4'b0 && !modemIrq));
endmodule

bind modem_status_watch modem_status_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .statusRd   (statusRd),
  .statusData (statusData),
  .modemIrq   (modemIrq)
);

// File: tb/modem_status_watch_tb.sv
module modem_status_watch_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] lines = 4'b1001;   // {carrier, ring, ready, cts}
  logic       statusRd = 1'b0;
  logic [7:0] statusData;
  logic       modemIrq;
  int runCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_watch u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .clearSendIn (lines[0]),
    .setReadyIn  (lines[1]),
    .ringIn      (lines[2]),
    .carrierIn   (lines[3]),
    .statusRd    (statusRd),
    .statusData  (statusData),
    .modemIrq    (modemIrq)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    runCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference: history of sampled pins
  logic [3:0] hist[$];
  logic [3:0] mFlag = 4'b0;
  logic [3:0] mLevel = 4'b0;

  always @(posedge clk) begin
    logic [3:0] nowV, oldV, hit;
    hit = 4'b0;
    if (hist.size() >= 3) begin
      nowV = hist[hist.size()-2];
      oldV = hist[hist.size()-3];
      for (int i = 0; i < 4; i++)
        hit[i] = (i == 2) ? (nowV[i] && !oldV[i]) : (nowV[i] != oldV[i]);
    end
    if (!rstN) mFlag <= 4'b0;
    else       mFlag <= (statusRd ? 4'b0 : mFlag) | hit;
    if (hist.size() >= 1) mLevel <= hist[hist.size()-1];
    hist.push_back(lines);
    if (hist.size() > 3) void'(hist.pop_front());
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(statusData == {mLevel, mFlag}, "R6 status vs model", statusData, {mLevel, mFlag});
      check(modemIrq == (mFlag != 4'b0), "R5 irq vs model", {7'b0, modemIrq}, {7'b0, mFlag != 4'b0});
    end
  end

  task automatic readStatus();
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    runCount++;
    failCount++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: lines high through reset, no flags afterwards
    check(statusData == 8'h90, "R8 reset state", statusData, 8'h90);
    check(modemIrq == 1'b0, "R8 irq after reset", {7'b0, modemIrq}, 8'h00);

    // R1/R6: clear to send falls
    lines[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(statusData == 8'h80, "R6 level after two edges", statusData, 8'h80);
    @(negedge clk);
    check(statusData == 8'h81, "R1 cts flag", statusData, 8'h81);
    check(modemIrq == 1'b1, "R5 irq raised", {7'b0, modemIrq}, 8'h01);

    // R3: held without read
    repeat (8) @(negedge clk);
    check(statusData[0] == 1'b1, "R3 flag held", statusData, 8'h81);
    readStatus();
    check(statusData == 8'h80, "R4 read clears", statusData, 8'h80);
    check(modemIrq == 1'b0, "R4 irq dropped", {7'b0, modemIrq}, 8'h00);

    // R1: ready rises, carrier falls together; R4 single read clears both
    lines[1] = 1'b1;
    lines[3] = 1'b0;
    repeat (3) @(negedge clk);
    check(statusData == 8'h2A, "R1 ready and carrier flags", statusData, 8'h2A);
    readStatus();
    check(statusData == 8'h20, "R4 read clears all", statusData, 8'h20);

    // R2: ring rise flags, ring fall ignored
    lines[2] = 1'b1;
    repeat (3) @(negedge clk);
    check(statusData == 8'h64, "R2 ring rise", statusData, 8'h64);
    readStatus();
    lines[2] = 1'b0;
    repeat (4) @(negedge clk);
    check(statusData == 8'h20, "R2 ring fall ignored", statusData, 8'h20);
    check(modemIrq == 1'b0, "R2 no irq on ring fall", {7'b0, modemIrq}, 8'h00);

    // R7: change lands in the read cycle; older flag still cleared
    lines[1] = 1'b0;
    repeat (3) @(negedge clk);
    check(statusData == 8'h02, "R7 setup ready flag", statusData, 8'h02);
    lines[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    check(statusData == 8'h11, "R7 coincident change kept", statusData, 8'h11);
    check(modemIrq == 1'b1, "R7 irq kept", {7'b0, modemIrq}, 8'h01);
    readStatus();
    check(statusData == 8'h10, "R4 final clear", statusData, 8'h10);

    // R4: read with nothing pending changes nothing
    readStatus();
    check(statusData == 8'h10, "R4 idle read", statusData, 8'h10);

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule